// File: doc/BRIEF.md
# Strip Readout Hit Buffer and Serial Shifter

This block is the digital back end of a 64-channel silicon-strip readout chip. It takes one discriminator bit per channel and qualifies it through two independent per-channel enable masks. One mask decides which channels reach the stored event data. The other decides which channels take part in the fast trigger. The trigger-enabled hits are ORed into a local fast-OR. That OR is merged with the fast-OR arriving from each neighbour and passed on to the neighbour on the opposite side, so a trigger can travel in either direction along a row of chips. A third per-channel mask, gated by a strobe, selects which channels receive a calibration test pulse.

On each read trigger the data-enabled hit pattern is written as one event into an eight-deep first-in-first-out buffer. A read command copies the oldest event, without removing it, into a serial lane. The lane is chained to its neighbours. The shift direction is chosen by a control bit, so a row of chips can be read from either end and a dead chip can be cut out of the chain. A chip whose head event has no hits, or that holds no event, drops to a one-stage pass-through. Its neighbours' data then crosses it in one shift instead of sixty-four. Data movement is a plain clocked shift driven by a shift enable. There is no valid/ready handshake, so a neighbour never sees back-pressure: every chip advances on the same enable.

Top module: `strip_hit_readout`

## Requirements
- R1: After reset the buffer is empty, the overflow flag is 0, both serial outputs are 0, the calibration outputs are 0 and the lane is in pass-through.
- R2: The local fast-OR is the OR of hit_i AND trig_en_i (1 = channel enabled). fo_right_o equals fo_left_i OR local, and fo_left_o equals fo_right_i OR local, with no clock delay.
- R3: A clock edge with trig_i high stores hit_i AND data_en_i (1 = enabled) as the newest event. Events leave in the order they were stored, and up to 8 are held.
- R4: trig_i with 8 events stored and no pop in the same cycle drops the event and sets ovf_o. ovf_o then stays 1 until clr_i or reset.
- R5: pop_i removes the oldest event, and pop_i on an empty buffer has no effect. trig_i and pop_i in the same cycle on a full buffer both take effect without overflow.
- R6: clr_i empties the buffer and clears ovf_o, and takes priority over trig_i and pop_i in the same cycle.
- R7: read_i loads the oldest event into the lane without removing it. Bit 0 appears on the serial output in the cycle after the load, and each edge with shift_i high advances one bit. With shift_i low the output holds.
- R8: With dir_i = 0, data enters on sdi_left_i and leaves on sdo_right_o, and sdo_left_o is held 0. With dir_i = 1 the roles mirror.
- R9: With a non-empty event loaded, a bit entering the serial input on a shift emerges on the serial output 64 shifts later, after the event's own bits.
- R10: A read of an empty buffer, or of an all-zero event, puts the lane in pass-through. The output is 0 right after the load, and each input bit appears one shift later.
- R11: cal_pulse_o equals cal_en_i in the cycle after a clock edge with cal_strobe_i high, and is 0 after an edge with cal_strobe_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 64 | Discriminator outputs, one per channel |
| data_en_i | input | 64 | Per-channel enable for stored event data |
| trig_en_i | input | 64 | Per-channel enable for the fast-OR |
| cal_en_i | input | 64 | Per-channel calibration select |
| cal_strobe_i | input | 1 | Calibration strobe |
| cal_pulse_o | output | 64 | Registered calibration pulse per channel |
| trig_i | input | 1 | Read trigger: capture one event |
| pop_i | input | 1 | Discard the oldest event |
| clr_i | input | 1 | Synchronous buffer clear |
| ovf_o | output | 1 | Sticky dropped-event flag |
| read_i | input | 1 | Load the oldest event into the serial lane |
| shift_i | input | 1 | Serial shift enable |
| dir_i | input | 1 | Shift direction, 0 = toward right, 1 = toward left |
| sdi_left_i | input | 1 | Serial data from the left neighbour |
| sdi_right_i | input | 1 | Serial data from the right neighbour |
| sdo_left_o | output | 1 | Serial data to the left neighbour |
| sdo_right_o | output | 1 | Serial data to the right neighbour |
| fo_left_i | input | 1 | Fast-OR arriving from the left neighbour |
| fo_right_i | input | 1 | Fast-OR arriving from the right neighbour |
| fo_left_o | output | 1 | Fast-OR sent to the left neighbour |
| fo_right_o | output | 1 | Fast-OR sent to the right neighbour |

## Verification
Event capture and head removal can land in the same cycle when the buffer already holds eight events. This is the one case where a capture must be accepted only because space frees up in that same edge. The bench fills the buffer, then raises trig_i and pop_i together on one edge. It judges the result by ovf_o staying low and by a later readout: the new head is the second event stored, and the event captured in that cycle comes out after the seven older ones.

// File: rtl/strip_ro_pkg.sv
package strip_ro_pkg;
  localparam int unsigned CHANNELS = 64;
  localparam int unsigned EVENTS   = 8;

  typedef enum logic {
    SHIFT_RIGHT = 1'b0,
    SHIFT_LEFT  = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/sro_fast_or.sv
module sro_fast_or #(
  parameter int unsigned NCH = 64
) (
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] trig_en_i,
  input  logic           fo_left_i,
  input  logic           fo_right_i,
  output logic           fo_left_o,
  output logic           fo_right_o
);
  localparam int unsigned SIDES = 2;

  logic       local_or;
  logic [SIDES-1:0] arrive;
  logic [SIDES-1:0] depart;

  assign local_or = |(hit_i & trig_en_i);
  assign arrive   = {fo_right_i, fo_left_i};

  // side 0: left arrival goes right; side 1: right arrival goes left
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign depart[s] = arrive[s] | local_or;
  end

  assign fo_right_o = depart[0];
  assign fo_left_o  = depart[1];
endmodule

// File: rtl/sro_event_fifo.sv
module sro_event_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               push_data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic                       head_valid_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_pop, do_push, drop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != FULL) || do_pop);
  assign drop    = push_i && !do_push;

  always_ff @(posedge clk) begin
    if (do_push && !clr_i) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign head_o       = mem[rd_q];
  assign head_valid_o = (cnt_q != '0);
  assign full_o       = (cnt_q == FULL);
  assign count_o      = cnt_q;
  assign ovf_o        = ovf_q;
endmodule

// File: rtl/sro_serial_lane.sv
module sro_serial_lane
  import strip_ro_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         load_valid_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  input  shift_dir_e   dir_i,
  input  logic         sdi_left_i,
  input  logic         sdi_right_i,
  output logic         sdo_left_o,
  output logic         sdo_right_o
);
  logic [W-1:0] sr_q;
  logic         pass_q;   // 1 = lane reduced to a single stage
  logic         stage_q;  // the single pass-through stage
  logic         sdi;
  logic         lane_out;

  assign sdi = (dir_i == SHIFT_LEFT) ? sdi_right_i : sdi_left_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      pass_q  <= 1'b1;
      stage_q <= 1'b0;
    end else if (load_i) begin
      stage_q <= 1'b0;
      if (load_valid_i && (|load_data_i)) begin
        sr_q   <= load_data_i;
        pass_q <= 1'b0;
      end else begin
        pass_q <= 1'b1;
      end
    end else if (shift_i) begin
      sr_q    <= {sdi, sr_q[W-1:1]};
      stage_q <= sdi;
    end
  end

  assign lane_out    = pass_q ? stage_q : sr_q[0];
  assign sdo_right_o = (dir_i == SHIFT_RIGHT) ? lane_out : 1'b0;
  assign sdo_left_o  = (dir_i == SHIFT_LEFT)  ? lane_out : 1'b0;
endmodule

// File: rtl/strip_hit_readout.sv
module strip_hit_readout
  import strip_ro_pkg::*;
#(
  parameter int unsigned NCH   = CHANNELS,
  parameter int unsigned DEPTH = EVENTS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] data_en_i,
  input  logic [NCH-1:0] trig_en_i,
  input  logic [NCH-1:0] cal_en_i,
  input  logic           cal_strobe_i,
  output logic [NCH-1:0] cal_pulse_o,
  input  logic           trig_i,
  input  logic           pop_i,
  input  logic           clr_i,
  output logic           ovf_o,
  input  logic           read_i,
  input  logic           shift_i,
  input  logic           dir_i,
  input  logic           sdi_left_i,
  input  logic           sdi_right_i,
  output logic           sdo_left_o,
  output logic           sdo_right_o,
  input  logic           fo_left_i,
  input  logic           fo_right_i,
  output logic           fo_left_o,
  output logic           fo_right_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [NCH-1:0] capture;
  logic [NCH-1:0] head;
  logic           head_valid;
  logic           fifo_full;
  logic [CW-1:0]  fifo_count;
  logic [NCH-1:0] cal_q;

  assign capture = hit_i & data_en_i;

  sro_fast_or #(.NCH(NCH)) u_fast_or (
    .hit_i      (hit_i),
    .trig_en_i  (trig_en_i),
    .fo_left_i  (fo_left_i),
    .fo_right_i (fo_right_i),
    .fo_left_o  (fo_left_o),
    .fo_right_o (fo_right_o)
  );

  sro_event_fifo #(.W(NCH), .DEPTH(DEPTH)) u_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .push_i       (trig_i),
    .push_data_i  (capture),
    .pop_i        (pop_i),
    .head_o       (head),
    .head_valid_o (head_valid),
    .full_o       (fifo_full),
    .count_o      (fifo_count),
    .ovf_o        (ovf_o)
  );

  sro_serial_lane #(.W(NCH)) u_lane (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (read_i),
    .load_valid_i (head_valid),
    .load_data_i  (head),
    .shift_i      (shift_i),
    .dir_i        (shift_dir_e'(dir_i)),
    .sdi_left_i   (sdi_left_i),
    .sdi_right_i  (sdi_right_i),
    .sdo_left_o   (sdo_left_o),
    .sdo_right_o  (sdo_right_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= '0;
    else        cal_q <= cal_strobe_i ? cal_en_i : '0;
  end

  assign cal_pulse_o = cal_q;
endmodule

// File: rtl/strip_hit_readout_chk.sv
module strip_hit_readout_chk #(
  parameter int unsigned NCH   = 64,
  parameter int unsigned DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             hit_i,
  input logic [NCH-1:0]             trig_en_i,
  input logic [NCH-1:0]             cal_en_i,
  input logic                       cal_strobe_i,
  input logic [NCH-1:0]             cal_pulse_o,
  input logic                       trig_i,
  input logic                       pop_i,
  input logic                       clr_i,
  input logic                       ovf_o,
  input logic                       read_i,
  input logic                       dir_i,
  input logic                       sdo_left_o,
  input logic                       sdo_right_o,
  input logic                       fo_left_i,
  input logic                       fo_right_i,
  input logic                       fo_left_o,
  input logic                       fo_right_o,
  input logic                       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  assert_fo_pass_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fo_left_i |-> fo_right_o);
  assert_fo_pass_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fo_right_i |-> fo_left_o);
  assert_fo_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_i & trig_en_i) != '0) |-> (fo_left_o && fo_right_o));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && fifo_full && !pop_i && !clr_i) |=> ovf_o);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);

  assert_swap_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && pop_i && fifo_full && !clr_i && !ovf_o) |=> (fifo_full && !ovf_o));

  assert_clr_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (fifo_count == '0 && !ovf_o));

  assert_dir_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i ? !sdo_right_o : !sdo_left_o));

  assert_bypass_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_i && fifo_count == '0 && !clr_i) |=> ($stable(dir_i) |-> !(sdo_left_o || sdo_right_o)));

  assert_cal_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cal_strobe_i |=> (cal_pulse_o == $past(cal_en_i)));
  assert_cal_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_strobe_i |=> (cal_pulse_o == '0));
endmodule

bind strip_hit_readout strip_hit_readout_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hit_i        (hit_i),
  .trig_en_i    (trig_en_i),
  .cal_en_i     (cal_en_i),
  .cal_strobe_i (cal_strobe_i),
  .cal_pulse_o  (cal_pulse_o),
  .trig_i       (trig_i),
  .pop_i        (pop_i),
  .clr_i        (clr_i),
  .ovf_o        (ovf_o),
  .read_i       (read_i),
  .dir_i        (dir_i),
  .sdo_left_o   (sdo_left_o),
  .sdo_right_o  (sdo_right_o),
  .fo_left_i    (fo_left_i),
  .fo_right_i   (fo_right_i),
  .fo_left_o    (fo_left_o),
  .fo_right_o   (fo_right_o),
  .fifo_full    (fifo_full),
  .fifo_count   (fifo_count)
);

// File: tb/strip_hit_readout_tb.sv
`timescale 1ns/1ps
module strip_hit_readout_tb;
  localparam int NCH = 64;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] hit = '0, data_en = '1, trig_en = '1, cal_en = '0, cal_pulse;
  logic cal_strobe = 0, trig = 0, pop = 0, clr = 0, ovf, rd = 0, shift = 0, dir = 0;
  logic sdi_l = 0, sdi_r = 0, sdo_l, sdo_r, fo_li = 0, fo_ri = 0, fo_lo, fo_ro;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  strip_hit_readout u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .data_en_i(data_en), .trig_en_i(trig_en),
    .cal_en_i(cal_en), .cal_strobe_i(cal_strobe), .cal_pulse_o(cal_pulse),
    .trig_i(trig), .pop_i(pop), .clr_i(clr), .ovf_o(ovf), .read_i(rd),
    .shift_i(shift), .dir_i(dir), .sdi_left_i(sdi_l), .sdi_right_i(sdi_r),
    .sdo_left_o(sdo_l), .sdo_right_o(sdo_r), .fo_left_i(fo_li), .fo_right_i(fo_ri),
    .fo_left_o(fo_lo), .fo_right_o(fo_ro));

  // fast-OR vectors: hit[131:68] trig_en[67:4] fo_left_i fo_right_i exp_right exp_left
  localparam logic [131:0] FO_VEC [7] = '{
    {64'h0,                  ONES,                   1'b0, 1'b0, 1'b0, 1'b0},
    {64'h20,                 ONES,                   1'b0, 1'b0, 1'b1, 1'b1},
    {64'h20,                 64'hFFFF_FFFF_FFFF_FFDF, 1'b0, 1'b0, 1'b0, 1'b0},
    {64'h0,                  ONES,                   1'b1, 1'b0, 1'b1, 1'b0},
    {64'h0,                  ONES,                   1'b0, 1'b1, 1'b0, 1'b1},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b1},
    {ONES,                   64'h0,                  1'b0, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [63:0] ev(input int i);
    return 64'h0123_4567_89AB_CDEF ^ {8{8'(i)}} ^ (64'(i) << 40);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic capture(input logic [63:0] h);
    @(negedge clk) hit = h; trig = 1;
    @(negedge clk) trig = 0; hit = '0;
  endtask

  task automatic pulse_pop();
    @(negedge clk) pop = 1;
    @(negedge clk) pop = 0;
  endtask

  task automatic read_bits(input logic d, input int n, input logic [127:0] feed,
                           output logic [127:0] got, output logic other);
    @(negedge clk) dir = d; rd = 1;
    @(negedge clk) rd = 0;
    got = '0; other = 0;
    for (int k = 0; k < n; k++) begin
      got[k] = d ? sdo_l : sdo_r;
      other  = other | (d ? sdo_r : sdo_l);
      if (d) sdi_r = feed[k]; else sdi_l = feed[k];
      shift = 1;
      @(negedge clk);
    end
    shift = 0; sdi_l = 0; sdi_r = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] got;
    logic other;
    logic [127:0] pat;
    pat = {64'h0, 64'hDEAD_BEEF_1357_9BDF};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ovf == 0, "R1", "ovf after reset", 128'(ovf), 0);
    check(sdo_r == 0 && sdo_l == 0, "R1", "serial outs after reset", {sdo_l, sdo_r}, 0);
    check(cal_pulse == 0, "R1", "cal after reset", 128'(cal_pulse), 0);
    read_bits(0, 4, 128'hA, got, other);
    check(got[3:0] == 4'h4, "R1", "empty buffer passes through", got[3:0], 4'h4);

    // R2 fast-OR vector table
    foreach (FO_VEC[i]) begin
      @(negedge clk);
      hit = FO_VEC[i][131:68]; trig_en = FO_VEC[i][67:4];
      fo_li = FO_VEC[i][3]; fo_ri = FO_VEC[i][2];
      #1;
      check({fo_ro, fo_lo} == FO_VEC[i][1:0], "R2", $sformatf("fast-OR vector %0d", i),
            {fo_ro, fo_lo}, FO_VEC[i][1:0]);
    end
    @(negedge clk) hit = '0; trig_en = '1; fo_li = 0; fo_ri = 0;

    // R3 capture with data mask, FIFO order; R7 read without pop
    data_en = 64'h0000_0000_FFFF_0000;
    capture(ev(2));
    data_en = '1;
    capture(ev(5));
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == (ev(2) & 64'h0000_0000_FFFF_0000), "R3", "masked first event",
          got[63:0], ev(2) & 64'h0000_0000_FFFF_0000);
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == (ev(2) & 64'h0000_0000_FFFF_0000), "R7", "read does not pop",
          got[63:0], ev(2) & 64'h0000_0000_FFFF_0000);
    pulse_pop();
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(5), "R3", "second event in order", got[63:0], ev(5));

    // R7 output holds without shift
    pulse_pop();
    capture(64'hA5);
    @(negedge clk) dir = 0; rd = 1;
    @(negedge clk) rd = 0;
    repeat (3) @(negedge clk);
    check(sdo_r == 1'b1, "R7", "bit0 held with shift low", 128'(sdo_r), 1);
    shift = 1; @(negedge clk) shift = 0;
    check(sdo_r == 1'b0, "R7", "bit1 after one shift", 128'(sdo_r), 0);

    // R9 chain length, R8 direction
    pulse_pop();
    capture(ev(4));
    read_bits(0, 128, pat, got, other);
    check(got == {pat[63:0], ev(4)}, "R9", "right shift 64-stage path", got, {pat[63:0], ev(4)});
    check(other == 0, "R8", "sdo_left quiet in right mode", 128'(other), 0);
    read_bits(1, 128, ~pat, got, other);
    check(got == {~pat[63:0], ev(4)}, "R8", "left shift path", got, {~pat[63:0], ev(4)});
    check(other == 0, "R8", "sdo_right quiet in left mode", 128'(other), 0);

    // R10 bypass: all-zero event, then empty buffer
    pulse_pop();
    data_en = '0;
    capture(ev(7));
    data_en = '1;
    read_bits(0, 16, pat, got, other);
    check(got[15:0] == {pat[14:0], 1'b0}, "R10", "zero event bypass", got[15:0], {pat[14:0], 1'b0});
    pulse_pop();
    read_bits(1, 16, pat, got, other);
    check(got[15:0] == {pat[14:0], 1'b0}, "R10", "empty buffer bypass left", got[15:0], {pat[14:0], 1'b0});

    // R4 overflow and stickiness
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;
    for (int i = 0; i < 8; i++) capture(ev(i));
    check(ovf == 0, "R4", "no overflow at 8 events", 128'(ovf), 0);
    capture(ev(8));
    check(ovf == 1, "R4", "overflow on ninth event", 128'(ovf), 1);
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(0), "R4", "head unchanged after drop", got[63:0], ev(0));
    for (int i = 0; i < 7; i++) pulse_pop();
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(7), "R4", "dropped event absent", got[63:0], ev(7));
    pulse_pop();
    read_bits(0, 8, pat, got, other);
    check(got[7:0] == {pat[6:0], 1'b0}, "R4", "buffer empty after pops", got[7:0], {pat[6:0], 1'b0});
    check(ovf == 1, "R4", "overflow sticky", 128'(ovf), 1);

    // R6 clear
    for (int i = 0; i < 3; i++) capture(ev(i));
    @(negedge clk) clr = 1; trig = 1; hit = ev(9);
    @(negedge clk) clr = 0; trig = 0; hit = '0;
    check(ovf == 0, "R6", "clear resets overflow", 128'(ovf), 0);
    read_bits(0, 8, pat, got, other);
    check(got[7:0] == {pat[6:0], 1'b0}, "R6", "clear empties buffer", got[7:0], {pat[6:0], 1'b0});

    // R5 simultaneous capture and pop on full buffer
    for (int i = 0; i < 8; i++) capture(ev(i));
    @(negedge clk) trig = 1; pop = 1; hit = ev(9);
    @(negedge clk) trig = 0; pop = 0; hit = '0;
    check(ovf == 0, "R5", "no overflow on swap", 128'(ovf), 0);
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(1), "R5", "head after swap", got[63:0], ev(1));
    for (int i = 0; i < 7; i++) pulse_pop();
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(9), "R5", "swapped-in event last", got[63:0], ev(9));

    // R5 pop on empty ignored
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;
    pulse_pop();
    capture(ev(3));
    read_bits(0, 64, '0, got, other);
    check(got[63:0] == ev(3), "R5", "pop on empty ignored", got[63:0], ev(3));

    // R11 calibration
    @(negedge clk) cal_en = 64'hF0F0_0000_1234_8001; cal_strobe = 1;
    @(negedge clk) cal_strobe = 0;
    check(cal_pulse == 64'hF0F0_0000_1234_8001, "R11", "cal pulse follows mask",
          128'(cal_pulse), 64'hF0F0_0000_1234_8001);
    @(negedge clk);
    check(cal_pulse == 0, "R11", "cal pulse drops", 128'(cal_pulse), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule